// File: doc/BRIEF.md
# Blacklist-Aware DRAM Request Arbiter

This block picks which queued read or write request a single-channel memory controller sends next. It holds a small table of pending requests. Each slot records the hardware context that issued the request, the bank and row it targets, and an age stamp that is assigned when the slot is written. Beside the table, one register per bank tracks which row is currently open in that bank.

Each cycle, a combinational selector ranks all valid slots using three keys in strict order. The first key is membership in the favoured group: the context's bit in the externally supplied blacklist vector is clear. The second key is whether the request hits the open row of its bank. The third key is age, and the older request wins. There is no per-context ranking. The winner is shown as a one-hot grant together with its slot index and request fields. When the downstream command logic accepts the grant, the slot is retired and the winner's row becomes the open row of its bank. Only one request can be issued per cycle.

Top module: `bliss_arbiter`

## Requirements
- R1: After reset no slot is valid: `grant_valid` is 0 and `grant_onehot` is all zeros.
- R2: A valid slot whose context bit in `blacklist` is 0 always wins over any slot whose context bit is 1, whatever their row-hit status and age.
- R3: Among slots equal on the blacklist key, a slot whose row equals the open row of its bank wins over a slot that misses, even when the missing slot is older.
- R4: Among slots equal on both earlier keys, the slot written earliest wins. Age stamps come from a counter that advances on every write, and stamps are compared modulo 2^AGE_W.
- R5: `grant_valid` is 1 exactly when at least one slot is valid. While it is 1, `grant_onehot` has only bit `grant_slot` set. While it is 0, `grant_onehot` is all zeros.
- R6: When `issue_accept` and `grant_valid` are both 1 at a clock edge, the granted slot becomes invalid, and its row becomes the open row of its bank from the next cycle on.
- R7: After reset every bank has no open row, so no request counts as a row hit until a request to that bank has been issued.
- R8: `issue_accept` while `grant_valid` is 0 changes neither the table nor any open row.
- R9: Writing a slot (`load_en`) makes it valid with a stamp younger than every earlier write. Rewriting a slot that is already valid makes it the youngest.
- R10: `blacklist` is not stored. A change to it moves the grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write a request into slot `load_slot` |
| load_slot | input | IDX_W | Slot being written |
| load_ctx | input | CTX_W | Originating hardware context |
| load_bank | input | BANK_W | Target bank |
| load_row | input | ROW_W | Target row |
| blacklist | input | NUM_CTX | One bit per context; 1 means deprioritized |
| issue_accept | input | 1 | Downstream takes the current grant |
| grant_valid | output | 1 | A grant is offered |
| grant_onehot | output | DEPTH | One-hot winning slot |
| grant_slot | output | IDX_W | Index of the winning slot |
| grant_ctx | output | CTX_W | Context of the winner |
| grant_bank | output | BANK_W | Bank of the winner |
| grant_row | output | ROW_W | Row of the winner |

## Verification
The bench sets up each priority key against the next key down. A young favoured miss competes with an old blacklisted hit, and a young hit competes with an old miss. A design that ordered the keys wrongly, or dropped one, would issue the older or blacklisted slot first. A request to row 0 of an unopened bank is placed after an older request. Open-row registers that came out of reset as valid row 0 would let the younger request win. The bench also rewrites a valid slot and toggles the blacklist while a grant is held steady. The first exposes stamps that are kept on rewrite. The second exposes a registered blacklist, which would leave the grant unchanged for one cycle. An accept pulse on an empty table checks that no phantom retirement or open-row update occurs.

// File: rtl/bliss_arb_pkg.sv
package bliss_arb_pkg;

    // Priority key of one request: compared as {favored, row_hit}.
    typedef struct packed {
        logic favored;
        logic row_hit;
    } prio_key_t;

    function automatic logic [1:0] key_rank(prio_key_t k);
        return {k.favored, k.row_hit};
    endfunction

endpackage

// File: rtl/bliss_req_table.sv
module bliss_req_table #(
    parameter int DEPTH  = 16,
    parameter int CTX_W  = 3,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int AGE_W  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [CTX_W-1:0]                 wr_ctx,
    input  logic [BANK_W-1:0]                wr_bank,
    input  logic [ROW_W-1:0]                 wr_row,
    input  logic                             retire_en,
    input  logic [IDX_W-1:0]                 retire_idx,
    output logic [DEPTH-1:0]                 slot_vld,
    output logic [DEPTH-1:0][CTX_W-1:0]      slot_ctx,
    output logic [DEPTH-1:0][BANK_W-1:0]     slot_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]      slot_row,
    output logic [DEPTH-1:0][AGE_W-1:0]      slot_age
);

    typedef struct packed {
        logic [CTX_W-1:0]  ctx;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [AGE_W-1:0]  age;
    } ent_t;

    typedef struct packed {
        logic [DEPTH-1:0]  vld;
        ent_t [DEPTH-1:0]  ent;
        logic [AGE_W-1:0]  stamp;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (retire_en) begin
            tbl_d.vld[retire_idx] = 1'b0;
        end
        // A write to the same slot in the same cycle takes precedence.
        if (wr_en) begin
            tbl_d.vld[wr_idx]      = 1'b1;
            tbl_d.ent[wr_idx].ctx  = wr_ctx;
            tbl_d.ent[wr_idx].bank = wr_bank;
            tbl_d.ent[wr_idx].row  = wr_row;
            tbl_d.ent[wr_idx].age  = tbl_q.stamp;
            tbl_d.stamp            = tbl_q.stamp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign slot_vld = tbl_q.vld;

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign slot_ctx[i]  = tbl_q.ent[i].ctx;
        assign slot_bank[i] = tbl_q.ent[i].bank;
        assign slot_row[i]  = tbl_q.ent[i].row;
        assign slot_age[i]  = tbl_q.ent[i].age;
    end

endmodule

// File: rtl/bliss_open_rows.sv
module bliss_open_rows #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                upd_en,
    input  logic [BANK_W-1:0]                   upd_bank,
    input  logic [ROW_W-1:0]                    upd_row,
    output logic [NUM_BANKS-1:0]                bank_open,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]     bank_row
);

    typedef struct packed {
        logic [NUM_BANKS-1:0]             open;
        logic [NUM_BANKS-1:0][ROW_W-1:0]  row;
    } rows_t;

    rows_t rows_d, rows_q;

    always_comb begin
        rows_d = rows_q;
        if (upd_en) begin
            rows_d.open[upd_bank] = 1'b1;
            rows_d.row[upd_bank]  = upd_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q <= '0;
        end else begin
            rows_q <= rows_d;
        end
    end

    assign bank_open = rows_q.open;
    assign bank_row  = rows_q.row;

endmodule

// File: rtl/bliss_pick.sv
module bliss_pick
    import bliss_arb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AGE_W  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             cand_vld,
    input  logic [DEPTH-1:0]             cand_favored,
    input  logic [DEPTH-1:0]             cand_hit,
    input  logic [DEPTH-1:0][AGE_W-1:0]  cand_age,
    output logic                         pick_vld,
    output logic [IDX_W-1:0]             pick_idx,
    output logic [DEPTH-1:0]             pick_onehot
);

    // Modular age compare: a is older than b when (a - b) is negative.
    function automatic logic is_older(logic [AGE_W-1:0] a, logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    prio_key_t        key;
    logic [1:0]       best_rank;
    logic [AGE_W-1:0] best_age;

    always_comb begin
        pick_vld  = 1'b0;
        pick_idx  = '0;
        best_rank = '0;
        best_age  = '0;
        key       = '0;
        // Ascending scan with strict comparisons: residual ties stay at the lowest index.
        for (int i = 0; i < DEPTH; i++) begin
            key.favored = cand_favored[i];
            key.row_hit = cand_hit[i];
            if (cand_vld[i]) begin
                if (!pick_vld || (key_rank(key) > best_rank) ||
                    ((key_rank(key) == best_rank) && is_older(cand_age[i], best_age))) begin
                    pick_vld  = 1'b1;
                    pick_idx  = IDX_W'(i);
                    best_rank = key_rank(key);
                    best_age  = cand_age[i];
                end
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_oh
        assign pick_onehot[i] = pick_vld && (pick_idx == IDX_W'(i));
    end

endmodule

// File: rtl/bliss_arbiter.sv
module bliss_arbiter #(
    parameter int DEPTH     = 16,
    parameter int NUM_CTX   = 8,
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int AGE_W     = 8,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CTX_W    = $clog2(NUM_CTX),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [IDX_W-1:0]   load_slot,
    input  logic [CTX_W-1:0]   load_ctx,
    input  logic [BANK_W-1:0]  load_bank,
    input  logic [ROW_W-1:0]   load_row,
    input  logic [NUM_CTX-1:0] blacklist,
    input  logic               issue_accept,
    output logic               grant_valid,
    output logic [DEPTH-1:0]   grant_onehot,
    output logic [IDX_W-1:0]   grant_slot,
    output logic [CTX_W-1:0]   grant_ctx,
    output logic [BANK_W-1:0]  grant_bank,
    output logic [ROW_W-1:0]   grant_row
);

    logic [DEPTH-1:0]                ent_vld;
    logic [DEPTH-1:0][CTX_W-1:0]     ent_ctx;
    logic [DEPTH-1:0][BANK_W-1:0]    ent_bank;
    logic [DEPTH-1:0][ROW_W-1:0]     ent_row;
    logic [DEPTH-1:0][AGE_W-1:0]     ent_age;
    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic [DEPTH-1:0]                ent_favored;
    logic [DEPTH-1:0]                ent_hit;
    logic                            fire;

    assign fire = issue_accept && grant_valid;

    bliss_req_table #(
        .DEPTH (DEPTH),
        .CTX_W (CTX_W),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .AGE_W (AGE_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (load_en),
        .wr_idx    (load_slot),
        .wr_ctx    (load_ctx),
        .wr_bank   (load_bank),
        .wr_row    (load_row),
        .retire_en (fire),
        .retire_idx(grant_slot),
        .slot_vld  (ent_vld),
        .slot_ctx  (ent_ctx),
        .slot_bank (ent_bank),
        .slot_row  (ent_row),
        .slot_age  (ent_age)
    );

    bliss_open_rows #(
        .NUM_BANKS(NUM_BANKS),
        .ROW_W    (ROW_W)
    ) i_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (fire),
        .upd_bank (grant_bank),
        .upd_row  (grant_row),
        .bank_open(bank_open),
        .bank_row (bank_row)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_key
        assign ent_favored[i] = !blacklist[ent_ctx[i]];
        assign ent_hit[i]     = bank_open[ent_bank[i]] &&
                                (bank_row[ent_bank[i]] == ent_row[i]);
    end

    bliss_pick #(
        .DEPTH(DEPTH),
        .AGE_W(AGE_W)
    ) i_pick (
        .cand_vld    (ent_vld),
        .cand_favored(ent_favored),
        .cand_hit    (ent_hit),
        .cand_age    (ent_age),
        .pick_vld    (grant_valid),
        .pick_idx    (grant_slot),
        .pick_onehot (grant_onehot)
    );

    assign grant_ctx  = ent_ctx[grant_slot];
    assign grant_bank = ent_bank[grant_slot];
    assign grant_row  = ent_row[grant_slot];

endmodule

// File: rtl/bliss_arb_chk.sv
module bliss_arb_chk #(
    parameter int DEPTH   = 16,
    parameter int NUM_CTX = 8,
    parameter int CTX_W   = 3,
    parameter int IDX_W   = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         load_en,
    input logic [IDX_W-1:0]             load_slot,
    input logic [NUM_CTX-1:0]           blacklist,
    input logic                         issue_accept,
    input logic                         grant_valid,
    input logic [DEPTH-1:0]             grant_onehot,
    input logic [IDX_W-1:0]             grant_slot,
    input logic [CTX_W-1:0]             grant_ctx,
    input logic [DEPTH-1:0]             ent_vld,
    input logic [DEPTH-1:0][CTX_W-1:0]  ent_ctx
);

    logic any_clean;
    always_comb begin
        any_clean = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_vld[i] && !blacklist[ent_ctx[i]]) any_clean = 1'b1;
        end
    end

    // R5
    onehot_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_onehot == (DEPTH'(1) << grant_slot)));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant_onehot == '0));

    // R5
    valid_iff_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (|ent_vld));

    // R2
    group_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && blacklist[grant_ctx]) |-> !any_clean);

    // R6
    retire_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_accept && grant_valid && !(load_en && load_slot == grant_slot))
        |=> !ent_vld[$past(grant_slot)]);

    // R8
    idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !load_en) |=> !grant_valid);

endmodule

bind bliss_arbiter bliss_arb_chk #(
    .DEPTH  (DEPTH),
    .NUM_CTX(NUM_CTX),
    .CTX_W  (CTX_W),
    .IDX_W  (IDX_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .load_slot   (load_slot),
    .blacklist   (blacklist),
    .issue_accept(issue_accept),
    .grant_valid (grant_valid),
    .grant_onehot(grant_onehot),
    .grant_slot  (grant_slot),
    .grant_ctx   (grant_ctx),
    .ent_vld     (ent_vld),
    .ent_ctx     (ent_ctx)
);

// File: tb/test_bliss_arbiter.sv
module test_bliss_arbiter;

    localparam int DEPTH = 16;
    localparam int NCTX  = 8;
    localparam int NBNK  = 8;
    localparam int ROW_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_en = 1'b0;
    logic [3:0]       load_slot = '0;
    logic [2:0]       load_ctx = '0;
    logic [2:0]       load_bank = '0;
    logic [ROW_W-1:0] load_row = '0;
    logic [NCTX-1:0]  blacklist = '0;
    logic             issue_accept = 1'b0;
    logic             grant_valid;
    logic [DEPTH-1:0] grant_onehot;
    logic [3:0]       grant_slot;
    logic [2:0]       grant_ctx;
    logic [2:0]       grant_bank;
    logic [ROW_W-1:0] grant_row;

    int checks = 0;
    int errors = 0;
    int          exp_q[$];
    string       req_q[$];

    always #5 clk = ~clk;

    bliss_arbiter #(
        .DEPTH(DEPTH), .NUM_CTX(NCTX), .NUM_BANKS(NBNK), .ROW_W(ROW_W), .AGE_W(8)
    ) i_bliss_arbiter (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_slot(load_slot),
        .load_ctx(load_ctx), .load_bank(load_bank), .load_row(load_row),
        .blacklist(blacklist), .issue_accept(issue_accept),
        .grant_valid(grant_valid), .grant_onehot(grant_onehot),
        .grant_slot(grant_slot), .grant_ctx(grant_ctx),
        .grant_bank(grant_bank), .grant_row(grant_row)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input int slot, input int ctx, input int bank, input int row);
        @(negedge clk);
        load_en   = 1'b1;
        load_slot = 4'(slot);
        load_ctx  = 3'(ctx);
        load_bank = 3'(bank);
        load_row  = ROW_W'(row);
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    // Driver: push the expected winner, then accept for one cycle.
    task automatic issue_expect(input int slot, input string req);
        exp_q.push_back(slot);
        req_q.push_back(req);
        @(negedge clk);
        issue_accept = 1'b1;
        @(negedge clk);
        issue_accept = 1'b0;
    endtask

    // Monitor: compare every accepted grant against the scoreboard.
    always @(negedge clk) begin
        #1;
        if (rst_n && issue_accept) begin
            if (exp_q.size() == 0) begin
                if (grant_valid) begin
                    checks++;
                    errors++;
                    $display("FAIL R8: actual grant slot %0d expected no grant", grant_slot);
                end
            end else begin
                int    e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, {31'd0, grant_valid}, 32'd1);
                check(r, 32'(grant_slot), 32'(e));
                check({r, " onehot"}, 32'(grant_onehot), 32'(1) << e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        check("R1 valid", {31'd0, grant_valid}, 32'd0);
        check("R1 onehot", 32'(grant_onehot), 32'd0);

        // R4 / R7: oldest first; bank 1 row 0 is not a hit after reset
        load(3, 1, 0, 5);
        load(1, 2, 1, 0);
        load(7, 3, 2, 9);
        issue_expect(3, "R7 closed rows, R4 oldest");
        issue_expect(1, "R4 second oldest");
        issue_expect(7, "R4 last");
        @(negedge clk);
        check("R5 empty valid", {31'd0, grant_valid}, 32'd0);
        check("R5 empty onehot", 32'(grant_onehot), 32'd0);

        // R8: accept with nothing to grant
        @(negedge clk); issue_accept = 1'b1;
        @(negedge clk); issue_accept = 1'b0;
        check("R8 no grant", {31'd0, grant_valid}, 32'd0);

        // R3 / R6: bank 0 open at row 5; young hit beats old miss
        load(2, 0, 0, 6);
        load(4, 0, 0, 5);
        issue_expect(4, "R3 hit over older miss");
        issue_expect(2, "R3 remaining miss");

        // R2: bank 1 open at row 0; blacklisted old hit loses to young miss
        blacklist = 8'b0000_0010;
        load(5, 1, 1, 0);
        load(9, 4, 4, 0);
        issue_expect(9, "R2 favored over blacklisted");
        issue_expect(5, "R2 blacklisted last");

        // R10: blacklist change moves grant in the same cycle
        blacklist = 8'b0000_0100;
        load(10, 2, 5, 1);
        load(11, 3, 5, 1);
        check("R10 initial", 32'(grant_slot), 32'd11);
        blacklist = 8'b0000_1000;
        #1;
        check("R10 after change", 32'(grant_slot), 32'd10);
        blacklist = '0;
        issue_expect(10, "R4 oldest after clear");
        issue_expect(11, "R4 remaining");

        // R6: open row follows the issued request
        load(12, 0, 6, 3);
        load(13, 0, 6, 8);
        issue_expect(12, "R4 oldest in bank 6");
        load(14, 0, 6, 3);
        issue_expect(14, "R6 open row updated to issued row");
        issue_expect(13, "R6 remaining");

        // R9: rewriting a valid slot makes it youngest
        load(0, 0, 7, 2);
        load(1, 0, 7, 2);
        check("R9 before rewrite", 32'(grant_slot), 32'd0);
        load(0, 0, 7, 2);
        issue_expect(1, "R9 rewritten slot now youngest");
        issue_expect(0, "R9 rewritten slot last");
        @(negedge clk);
        check("R5 drained", {31'd0, grant_valid}, 32'd0);
        check("scoreboard empty", 32'(exp_q.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule